// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block maps addresses that land inside a graphics aperture window onto physical memory pages. The aperture offset (request address minus the aperture base) is split into a directory index, a second-level index and a byte offset within a 4 KB page. The first level is a 64-entry directory held in flops and loaded one entry at a time through a single packed 32-bit write port. The second level lives in memory: each directory entry points at one 4 KB table page of 1024 four-byte entries, fetched over a simple read request and response port.

A small fully associative translation cache keeps recent page translations so that repeated accesses to the same page skip the memory read. Software flushes the cache with a control write that first clears bit 7 and then sets it. Requests enter through a valid/ready handshake. Only one request is in flight at a time, and each request ends with a one-cycle response that carries either a physical address or a fault.

Top module: `aper_xlate`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_o` are 0. The cache is empty, so the first request to any page issues a memory read.
- R2: A directory write with bit 8 set marks the entry chosen by bits 5:0 present, with its table page taken from bits 31:12. Bits 11:9 (attribute index) and bits 7:6 do not affect translation.
- R3: A directory write with bit 8 clear makes the chosen entry absent. The directory is checked before the cache, so any request through an absent entry faults without a memory read, even if its page is cached.
- R4: The offset is `req_addr_i - aper_base_i`, taken modulo 2^32. The size code sets the window: code 0 gives 256 MB, 32 gives 128 MB, 48 gives 64 MB and 56 gives 32 MB. An offset at or beyond the window size faults without a memory read. Any other size code makes every request fault.
- R5: The directory index is offset bits 27:22. The second-level read address is {table page, offset[21:12], 2'b00}.
- R6: A second-level entry is valid when bit 0 is 1. Its bits 31:12 then give the physical page, and the response address is {entry[31:12], offset[11:0]}. If bit 0 is 0, the request faults.
- R7: A request to a page that is already cached issues no memory read. Its response appears two cycles after the acceptance edge, counted in falling edges from the cycle of the request.
- R8: The cache holds 4 entries and replaces them round-robin, starting from slot 0 after a flush. After five distinct pages are filled, the third page still hits and the first page misses.
- R9: A control write with bit 7 set flushes the cache only if the previous control write had bit 7 clear. The value after reset counts as set. All other control bits are ignored. Without a flush, a cached translation survives a rewrite of its directory entry.
- R10: `req_ready_o` stays low from acceptance until the response. `rsp_valid_o` lasts exactly one cycle. `mem_req_o` and `mem_addr_o` hold steady until `mem_rsp_valid_i`, so a miss with memory latency L responds L+2 cycles after the request.
- R11: A fault response carries physical address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| aper_base_i | input | 32 | Aperture base address |
| size_code_i | input | 8 | Aperture size code |
| dir_wr_i | input | 1 | Directory load strobe |
| dir_wdata_i | input | 32 | Packed directory load value |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 32 | Control write value |
| req_valid_i | input | 1 | Translation request valid |
| req_addr_i | input | 32 | Address to translate |
| req_ready_o | output | 1 | Block can accept a request |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 1 | Response is a fault |
| rsp_paddr_o | output | 32 | Translated physical address |
| mem_req_o | output | 1 | Second-level read request, held until answered |
| mem_addr_o | output | 32 | Second-level entry address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Second-level entry read back |

## Verification
The assertions watch the handshake on every cycle. They check that ready drops after acceptance, that a response is a single pulse, that a read request is held steady and never overlaps a response, and that a fault carries a zero address. They also check the state rules: a directory load or clear takes effect, cached tags never match twice, and a flush empties the cache. The bench scenarios cover what only a sequence of operations can show: address splitting against a memory model, the window limit for each size code, round-robin eviction order, stale hits after a directory rewrite, and the difference between a set-only control write and a clear-then-set pair.

// File: rtl/aper_pkg.sv
package aper_pkg;
    localparam int ADDR_W      = 32;
    localparam int PAGE_SHIFT  = 12;
    localparam int L2_IDX_W    = 10;
    localparam int DIR_ENTRIES = 64;
    localparam int DIR_IDX_W   = $clog2(DIR_ENTRIES);
    localparam int DIR_LSB     = PAGE_SHIFT + L2_IDX_W;
    localparam int VPN_W       = DIR_IDX_W + L2_IDX_W;
    localparam int PFN_W       = ADDR_W - PAGE_SHIFT;
    localparam int PRESENT_BIT = 8;
    localparam int FLUSH_BIT   = 7;
    localparam int L2_VALID_BIT = 0;

    localparam logic [7:0] SZ_256M = 8'd0;
    localparam logic [7:0] SZ_128M = 8'd32;
    localparam logic [7:0] SZ_64M  = 8'd48;
    localparam logic [7:0] SZ_32M  = 8'd56;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOK  = 2'd1,
        ST_FETCH = 2'd2,
        ST_RESP  = 2'd3
    } st_e;

    function automatic logic in_window(input logic [ADDR_W-1:0] off, input logic [7:0] code);
        case (code)
            SZ_256M: return off[ADDR_W-1:28] == '0;
            SZ_128M: return off[ADDR_W-1:27] == '0;
            SZ_64M:  return off[ADDR_W-1:26] == '0;
            SZ_32M:  return off[ADDR_W-1:25] == '0;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/aper_dir.sv
module aper_dir
    import aper_pkg::*;
#(
    parameter int ENTRIES = DIR_ENTRIES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    wdata_i,
    input  logic [DIR_IDX_W-1:0] rd_idx_i,
    output logic                 rd_present_o,
    output logic [PFN_W-1:0]     rd_pfn_o
);
    typedef struct packed {
        logic [ENTRIES-1:0]            present;
        logic [ENTRIES-1:0][PFN_W-1:0] pfn;
    } dir_s;

    dir_s s_q, s_d;
    logic [DIR_IDX_W-1:0] wr_idx;
    logic                 unused_attr;

    assign wr_idx      = wdata_i[DIR_IDX_W-1:0];
    assign unused_attr = ^wdata_i[PAGE_SHIFT-1:PRESENT_BIT+1] ^ ^wdata_i[PRESENT_BIT-1:DIR_IDX_W];

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            s_d.present[wr_idx] = wdata_i[PRESENT_BIT];
            if (wdata_i[PRESENT_BIT]) begin
                s_d.pfn[wr_idx] = wdata_i[ADDR_W-1:PAGE_SHIFT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_present_o = s_q.present[rd_idx_i];
    assign rd_pfn_o     = s_q.pfn[rd_idx_i];

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && wdata_i[PRESENT_BIT] |=> s_q.present[$past(wr_idx)] &&
            s_q.pfn[$past(wr_idx)] == $past(wdata_i[ADDR_W-1:PAGE_SHIFT]));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && !wdata_i[PRESENT_BIT] |=> !s_q.present[$past(wr_idx)]);
endmodule

// File: rtl/aper_tlb.sv
module aper_tlb
    import aper_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] look_vpn_i,
    output logic             hit_o,
    output logic [PFN_W-1:0] hit_pfn_o,
    input  logic             fill_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PFN_W-1:0] fill_pfn_i,
    input  logic             flush_i
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][VPN_W-1:0] tag;
        logic [ENTRIES-1:0][PFN_W-1:0] pfn;
        logic [PTR_W-1:0]              ptr;
    } tlb_s;

    tlb_s s_q, s_d;
    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = s_q.valid[g] && (s_q.tag[g] == look_vpn_i);
    end

    always_comb begin
        hit_pfn_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_pfn_o = hit_pfn_o | s_q.pfn[i];
        end
    end
    assign hit_o = |hit_vec;

    always_comb begin
        s_d = s_q;
        if (flush_i) begin
            s_d.valid = '0;
            s_d.ptr   = '0;
        end else if (fill_i) begin
            s_d.valid[s_q.ptr] = 1'b1;
            s_d.tag[s_q.ptr]   = fill_vpn_i;
            s_d.pfn[s_q.ptr]   = fill_pfn_i;
            s_d.ptr            = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_unique_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> s_q.valid == '0);
endmodule

// File: rtl/aper_xlate.sv
module aper_xlate
    import aper_pkg::*;
#(
    parameter int TLB_ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] aper_base_i,
    input  logic [7:0]        size_code_i,
    input  logic              dir_wr_i,
    input  logic [ADDR_W-1:0] dir_wdata_i,
    input  logic              ctl_wr_i,
    input  logic [ADDR_W-1:0] ctl_wdata_i,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              req_ready_o,
    output logic              rsp_valid_o,
    output logic              rsp_fault_o,
    output logic [ADDR_W-1:0] rsp_paddr_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [ADDR_W-1:0] mem_rsp_data_i
);
    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] off;
        logic              fault;
        logic [ADDR_W-1:0] paddr;
        logic              fill_ok;
        logic              ctl_b7;
    } core_s;

    core_s s_q, s_d;

    logic             dir_present;
    logic [PFN_W-1:0] dir_pfn;
    logic             tlb_hit;
    logic [PFN_W-1:0] tlb_pfn;
    logic             tlb_fill;
    logic             flush;
    logic             unused_bits;

    assign unused_bits = ^mem_rsp_data_i[PAGE_SHIFT-1:L2_VALID_BIT+1]
                       ^ ^ctl_wdata_i[ADDR_W-1:FLUSH_BIT+1] ^ ^ctl_wdata_i[FLUSH_BIT-1:0];

    assign flush = ctl_wr_i && ctl_wdata_i[FLUSH_BIT] && !s_q.ctl_b7;

    aper_dir #(.ENTRIES(DIR_ENTRIES)) u_dir (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (dir_wr_i),
        .wdata_i      (dir_wdata_i),
        .rd_idx_i     (s_q.off[DIR_LSB +: DIR_IDX_W]),
        .rd_present_o (dir_present),
        .rd_pfn_o     (dir_pfn)
    );

    aper_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_vpn_i (s_q.off[PAGE_SHIFT +: VPN_W]),
        .hit_o      (tlb_hit),
        .hit_pfn_o  (tlb_pfn),
        .fill_i     (tlb_fill),
        .fill_vpn_i (s_q.off[PAGE_SHIFT +: VPN_W]),
        .fill_pfn_i (mem_rsp_data_i[ADDR_W-1:PAGE_SHIFT]),
        .flush_i    (flush)
    );

    always_comb begin
        s_d      = s_q;
        tlb_fill = 1'b0;
        if (ctl_wr_i) s_d.ctl_b7 = ctl_wdata_i[FLUSH_BIT];
        if (flush)    s_d.fill_ok = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    s_d.off     = req_addr_i - aper_base_i;
                    s_d.fill_ok = 1'b1;
                    s_d.st      = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (!in_window(s_q.off, size_code_i) || !dir_present) begin
                    s_d.fault = 1'b1;
                    s_d.paddr = '0;
                    s_d.st    = ST_RESP;
                end else if (tlb_hit) begin
                    s_d.fault = 1'b0;
                    s_d.paddr = {tlb_pfn, s_q.off[PAGE_SHIFT-1:0]};
                    s_d.st    = ST_RESP;
                end else begin
                    s_d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_rsp_valid_i) begin
                    if (mem_rsp_data_i[L2_VALID_BIT]) begin
                        s_d.fault = 1'b0;
                        s_d.paddr = {mem_rsp_data_i[ADDR_W-1:PAGE_SHIFT], s_q.off[PAGE_SHIFT-1:0]};
                        tlb_fill  = s_q.fill_ok && !flush;
                    end else begin
                        s_d.fault = 1'b1;
                        s_d.paddr = '0;
                    end
                    s_d.st = ST_RESP;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.ctl_b7 <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready_o = (s_q.st == ST_IDLE);
    assign rsp_valid_o = (s_q.st == ST_RESP);
    assign rsp_fault_o = s_q.fault;
    assign rsp_paddr_o = s_q.paddr;
    assign mem_req_o   = (s_q.st == ST_FETCH);
    assign mem_addr_o  = {dir_pfn, s_q.off[PAGE_SHIFT +: L2_IDX_W], 2'b00};

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_ready_o |=> !req_ready_o);

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o && req_ready_o);

    p_one_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !req_ready_o && !rsp_valid_o);

    p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_rsp_valid_i && !dir_wr_i |=> mem_req_o && $stable(mem_addr_o));

    p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_fault_o |-> rsp_paddr_o == '0);
endmodule

// File: tb/aper_xlate_test.sv
module aper_xlate_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;
    localparam int WATCHDOG   = 150000;
    localparam logic [31:0] BASE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] aper_base;
    logic [7:0]  size_code;
    logic        dir_wr;
    logic [31:0] dir_wdata;
    logic        ctl_wr;
    logic [31:0] ctl_wdata;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_ready_o, rsp_valid_o, rsp_fault_o, mem_req_o;
    logic [31:0] rsp_paddr_o, mem_addr_o;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int tests = 0;
    int fails = 0;
    int fetch_cnt = 0;
    logic [31:0] last_maddr = '0;
    logic        dir_pres [64];
    logic [19:0] dir_pfn  [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    aper_xlate uut (
        .clk (clk), .rst_n (rst_n), .aper_base_i (aper_base), .size_code_i (size_code),
        .dir_wr_i (dir_wr), .dir_wdata_i (dir_wdata), .ctl_wr_i (ctl_wr), .ctl_wdata_i (ctl_wdata),
        .req_valid_i (req_valid), .req_addr_i (req_addr), .req_ready_o (req_ready_o),
        .rsp_valid_o (rsp_valid_o), .rsp_fault_o (rsp_fault_o), .rsp_paddr_o (rsp_paddr_o),
        .mem_req_o (mem_req_o), .mem_addr_o (mem_addr_o),
        .mem_rsp_valid_i (mem_rsp_valid), .mem_rsp_data_i (mem_rsp_data)
    );

    function automatic logic [31:0] l2_word(input logic [31:0] a);
        logic [31:0] h;
        h = a * 32'h9E37_79B1;
        h = h ^ (h >> 13);
        return {h[31:12], 11'h5A5, (a[4:2] != 3'd7)};
    endfunction

    function automatic longint win_bytes(input logic [7:0] code);
        case (code)
            8'd0:    return 64'd1 << 28;
            8'd32:   return 64'd1 << 27;
            8'd48:   return 64'd1 << 26;
            8'd56:   return 64'd1 << 25;
            default: return 64'd0;
        endcase
    endfunction

    function automatic void model(input logic [31:0] addr, output logic f, output logic [31:0] p);
        logic [31:0] off, w;
        logic [5:0]  idx;
        off = addr - aper_base;
        idx = off[27:22];
        f = 1'b1;
        p = '0;
        if (longint'(off) < win_bytes(size_code) && dir_pres[idx]) begin
            w = l2_word({dir_pfn[idx], off[21:12], 2'b00});
            if (w[0]) begin
                f = 1'b0;
                p = {w[31:12], off[11:0]};
            end
        end
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic dir_write(input int idx, input logic [19:0] pfn, input logic pres);
        @(negedge clk);
        dir_wr    = 1'b1;
        dir_wdata = {pfn, 3'b101, pres, 2'b00, 6'(idx)};
        @(negedge clk);
        dir_wr = 1'b0;
        dir_pres[idx] = pres;
        if (pres) dir_pfn[idx] = pfn;
    endtask

    task automatic ctl_write(input logic [31:0] v);
        @(negedge clk);
        ctl_wr    = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] addr, output logic f, output logic [31:0] p,
                         output int lat, output int nf);
        int f0;
        logic hs_ok;
        hs_ok = 1'b1;
        while (!req_ready_o) @(negedge clk);
        f0 = fetch_cnt;
        req_valid = 1'b1;
        req_addr  = addr;
        lat = 0;
        forever begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
            if (rsp_valid_o) break;
            if (req_ready_o) hs_ok = 1'b0;
            if (lat > 500) begin hs_ok = 1'b0; break; end
        end
        f  = rsp_fault_o;
        p  = rsp_paddr_o;
        nf = fetch_cnt - f0;
        @(negedge clk);
        chk(hs_ok && !rsp_valid_o && req_ready_o, "R10 handshake", {31'd0, rsp_valid_o}, 32'd0);
    endtask

    task automatic run_one(input logic [31:0] addr, input string req,
                           input int exp_nf, input int exp_lat);
        logic f, ef;
        logic [31:0] p, ep;
        int lat, nf;
        model(addr, ef, ep);
        xlate(addr, f, p, lat, nf);
        chk(f == ef, req, {31'd0, f}, {31'd0, ef});
        chk(p == ep, req, p, ep);
        if (exp_nf >= 0)  chk(nf == exp_nf, req, nf, exp_nf);
        if (exp_lat >= 0) chk(lat == exp_lat, req, lat, exp_lat);
    endtask

    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_o) begin
                fetch_cnt++;
                last_maddr = mem_addr_o;
                repeat (MEM_LAT - 1) @(negedge clk);
                mem_rsp_data  = l2_word(last_maddr);
                mem_rsp_valid = 1'b1;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic f;
        logic [31:0] p;
        int lat, nf;
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) begin dir_pres[i] = 1'b0; dir_pfn[i] = '0; end
        rst_n = 1'b0; aper_base = BASE; size_code = 8'd0;
        dir_wr = 0; dir_wdata = 0; ctl_wr = 0; ctl_wdata = 0; req_valid = 0; req_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready_o && !rsp_valid_o && !mem_req_o, "R1 reset outputs",
            {29'd0, req_ready_o, rsp_valid_o, mem_req_o}, 32'h4);

        for (int i = 0; i < 4; i++) dir_write(i, 20'h00100 + 20'(i), 1'b1);
        dir_write(7, 20'h00777, 1'b1);
        ctl_write(32'h2200);
        ctl_write(32'h2280);

        // R5 R6 R1: first access misses, address split and read address
        run_one(BASE + 32'h0000_3ABC, "R5 R6 miss translate", 1, 2 + MEM_LAT);
        chk(last_maddr == {20'h00100, 10'h003, 2'b00}, "R5 read address",
            last_maddr, {20'h00100, 10'h003, 2'b00});
        // R7: same page hits
        run_one(BASE + 32'h0000_3004, "R7 hit", 0, 2);
        // R6 R11: invalid second-level entry
        run_one(BASE + 32'h0000_7010, "R6 R11 invalid entry", 1, -1);
        // R3: absent directory entry
        run_one(BASE + (32'd9 << 22), "R3 absent entry", 0, 2);
        dir_write(0, 20'h00100, 1'b0);
        run_one(BASE + 32'h0000_3ABC, "R3 absent beats cache", 0, 2);
        dir_write(0, 20'h00100, 1'b1);
        run_one(BASE + 32'h0000_3ABC, "R2 reload hit", 0, 2);

        // R4: windows
        run_one(BASE + 32'h1000_0000, "R4 256M edge", 0, 2);
        run_one(BASE - 32'h1000, "R4 below base", 0, 2);
        size_code = 8'd56;
        run_one(BASE + 32'h0200_0000, "R4 32M edge", 0, 2);
        run_one(BASE + 32'h01FF_F123, "R4 32M last page", 1, -1);
        size_code = 8'd48;
        run_one(BASE + 32'h0400_0000, "R4 64M edge", 0, 2);
        size_code = 8'd32;
        run_one(BASE + 32'h0800_0000, "R4 128M edge", 0, 2);
        run_one(BASE + 32'h0000_1008, "R4 128M inside", 1, -1);
        size_code = 8'd8;
        run_one(BASE + 32'h0000_3ABC, "R4 unknown code", 0, 2);
        size_code = 8'd0;

        // R8: round-robin eviction
        ctl_write(32'h0000);
        ctl_write(32'h0080);
        for (int k = 0; k < 5; k++) run_one(BASE + 32'h0040_0000 + 32'(k) * 32'h1000, "R8 fill", 1, -1);
        run_one(BASE + 32'h0040_2000, "R8 third page kept", 0, 2);
        run_one(BASE + 32'h0040_0000, "R8 first page evicted", 1, -1);

        // R9: stale until a clear-then-set flush
        xlate(BASE + 32'h0040_0040, f, p, lat, nf);
        begin
            logic ef; logic [31:0] old_p;
            model(BASE + 32'h0040_0040, ef, old_p);
            dir_write(1, 20'h00200, 1'b1);
            xlate(BASE + 32'h0040_0040, f, p, lat, nf);
            chk(p == old_p && nf == 0, "R9 stale after dir rewrite", p, old_p);
            ctl_write(32'h2280);
            xlate(BASE + 32'h0040_0040, f, p, lat, nf);
            chk(p == old_p && nf == 0, "R9 set-only write no flush", p, old_p);
            ctl_write(32'hFFFF_FF7F);
            ctl_write(32'h0000_0080);
        end
        run_one(BASE + 32'h0040_0040, "R9 after flush", 1, 2 + MEM_LAT);

        // random phase
        for (int n = 0; n < 300; n++) begin
            logic [31:0] off;
            longint lim;
            if (($urandom % 16) == 0) begin
                dir_write($urandom % 64, 20'($urandom), ($urandom % 4) != 0);
                ctl_write(32'h2200);
                ctl_write(32'h2280);
            end
            case ($urandom % 4)
                0: size_code = 8'd0;
                1: size_code = 8'd32;
                2: size_code = 8'd48;
                default: size_code = 8'd56;
            endcase
            lim = win_bytes(size_code);
            off = 32'($urandom % 64'(lim + lim / 4));
            run_one(BASE + off, "R4 R6 random", -1, -1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule